// File: doc/BRIEF.md
# GPIO Pin Interrupt Detection Unit

This unit watches 32 general-purpose input pins and turns their activity into interrupt requests. The pins form two banks of sixteen: pins 0 to 15 (low bank) and pins 16 to 31 (high bank). Each bank has its own set of 16-bit registers, reached through a simple word-addressed write port with a combinational read path.

Each pin is configured on its own. It can be level or edge triggered. In level mode it can be active high or active low. In edge mode, rising and falling edges are enabled separately. An edge event can either be latched until software clears it, or shown for a single cycle only. Pending, enabled pins are ORed into one request line. A priority selector reports the index of the pin that should be serviced, and raises a spurious flag when nothing enabled is pending.

Top module: `gpio_irq_unit`

## Requirements
- R1: Registers are 16 bits wide, at even byte addresses. The bank is chosen by address bit 1 (0 = pins 0–15, 1 = pins 16–31). The low/high addresses are: pending status 0x08/0x0A, mask enable 0x0C/0x0E, trigger type 0x10/0x12, polarity 0x14/0x16, latch select 0x18/0x1A, falling-edge select 0x20/0x22, rising-edge select 0x24/0x26. Every configuration and enable register reads back the value last written to it.
- R2: After reset, all enable and configuration registers read 0, `irq_o` is 0 and `spurious_o` is 1.
- R3: When the trigger type bit is 0 (level mode), the status bit follows the pin on every cycle. The pin counts as active when it equals the polarity bit (1 = active high, 0 = active low). A pin change appears in status on the third rising clock edge after it is applied: two synchronizer flops plus the status flop.
- R4: When the trigger type bit is 1 (edge mode), an event is produced as follows: rising-edge select alone reacts to 0→1, falling-edge select alone reacts to 1→0, both react to either edge, and neither reacts to nothing. An edge is detected by comparing the synchronized pin with its value one cycle earlier.
- R5: In edge mode with the latch select bit at 1, an event sets the status bit and it stays set. With the latch select bit at 0, status is high only in the single cycle of the event.
- R6: Writing the status register clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R7: `irq_o` is 1 exactly when some pin in either bank has both its status bit and its enable bit set.
- R8: `pend_idx_o` gives the lowest-numbered pin in the low bank that is both pending and enabled. The high bank is considered only if no such low-bank pin exists. When no pin is pending and enabled, `spurious_o` is 1 and `pend_idx_o` is 0.
- R9: Clearing an enable bit removes that pin from `irq_o` and from `pend_idx_o`, but leaves its status bit unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 32 | Asynchronous pin inputs |
| addr_i | input | 6 | Byte address of the register being accessed |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i` (combinational) |
| irq_o | output | 1 | Combined interrupt request |
| pend_idx_o | output | 5 | Index of the pin to service |
| spurious_o | output | 1 | No enabled pin is pending |

## Verification
The bench builds the unit with its defaults: two 16-pin banks and a two-stage synchronizer. With these values a sweep over all 32 pins is affordable in both level and latched-edge modes. Each pin is driven one-hot, and both the register value and the reported index are predicted from the pin number. Directed sequences then cover the edge-select combinations, the single-cycle pulse in unlatched mode, clear-by-one, masking, and the low-before-high priority order.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int BANK_W    = 16;
    localparam int NUM_BANKS = 2;
    localparam int PINS      = BANK_W * NUM_BANKS;
    localparam int ADDR_W    = 6;
    localparam int BIDX_W    = $clog2(BANK_W);
    localparam int IDX_W     = $clog2(PINS);

    typedef enum logic [2:0] {
        RK_STAT, RK_EN, RK_TYPE, RK_POL, RK_HOLD, RK_FALL, RK_RISE, RK_NONE
    } reg_kind_e;

    typedef struct packed {
        logic [BANK_W-1:0] typ;
        logic [BANK_W-1:0] pol;
        logic [BANK_W-1:0] hold;
        logic [BANK_W-1:0] fall;
        logic [BANK_W-1:0] rise;
    } bank_cfg_t;

    // Address bit 1 picks the bank; the remaining bits pick the function.
    function automatic reg_kind_e decode_kind(input logic [ADDR_W-1:0] a);
        reg_kind_e k;
        if (a[0]) begin
            k = RK_NONE;
        end else begin
            case ({a[5:2], 2'b00})
                6'h08:   k = RK_STAT;
                6'h0C:   k = RK_EN;
                6'h10:   k = RK_TYPE;
                6'h14:   k = RK_POL;
                6'h18:   k = RK_HOLD;
                6'h20:   k = RK_FALL;
                6'h24:   k = RK_RISE;
                default: k = RK_NONE;
            endcase
        end
        return k;
    endfunction

    function automatic logic [BIDX_W-1:0] lowest_set(input logic [BANK_W-1:0] v);
        logic [BIDX_W-1:0] r;
        r = '0;
        for (int i = BANK_W - 1; i >= 0; i--) begin
            if (v[i]) r = i[BIDX_W-1:0];
        end
        return r;
    endfunction

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= d;
            for (int k = 1; k < STAGES; k++) begin
                chain_q[k] <= chain_q[k-1];
            end
        end
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_irq_pkg::*;
#(
    parameter int BANK_ID = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BANK_W-1:0] sync_i,
    input  logic              wr_en,
    input  reg_kind_e         wr_kind,
    input  logic              wr_bank,
    input  logic [BANK_W-1:0] wdata,
    output logic [BANK_W-1:0] stat_o,
    output logic [BANK_W-1:0] en_o,
    output bank_cfg_t         cfg_o
);
    logic [BANK_W-1:0] prev_q, stat_q, en_q;
    bank_cfg_t         cfg_q;
    logic              hit;
    logic [BANK_W-1:0] rise_ev, fall_ev, edge_ev, lvl_act, clr, stat_n;

    assign hit     = wr_en && (wr_bank == BANK_ID[0]);
    assign rise_ev = sync_i & ~prev_q;
    assign fall_ev = ~sync_i & prev_q;
    assign edge_ev = (rise_ev & cfg_q.rise) | (fall_ev & cfg_q.fall);
    assign lvl_act = ~(sync_i ^ cfg_q.pol);
    assign clr     = (hit && wr_kind == RK_STAT) ? wdata : '0;

    // Level: follow active level. Edge latched: set on event, clear by one.
    // Edge through: one-cycle pulse on event.
    assign stat_n = (~cfg_q.typ & lvl_act)
                  | (cfg_q.typ & cfg_q.hold & ((stat_q & ~clr) | edge_ev))
                  | (cfg_q.typ & ~cfg_q.hold & edge_ev);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            stat_q <= '0;
            en_q   <= '0;
            cfg_q  <= '0;
        end else begin
            prev_q <= sync_i;
            stat_q <= stat_n;
            if (hit) begin
                case (wr_kind)
                    RK_EN:   en_q       <= wdata;
                    RK_TYPE: cfg_q.typ  <= wdata;
                    RK_POL:  cfg_q.pol  <= wdata;
                    RK_HOLD: cfg_q.hold <= wdata;
                    RK_FALL: cfg_q.fall <= wdata;
                    RK_RISE: cfg_q.rise <= wdata;
                    default: ;
                endcase
            end
        end
    end

    assign stat_o = stat_q;
    assign en_o   = en_q;
    assign cfg_o  = cfg_q;
endmodule

// File: rtl/gpio_irq_prio.sv
module gpio_irq_prio
    import gpio_irq_pkg::*;
(
    input  logic [BANK_W-1:0] lo_i,
    input  logic [BANK_W-1:0] hi_i,
    output logic [IDX_W-1:0]  idx_o,
    output logic              spurious_o
);
    logic any_lo, any_hi;

    assign any_lo = |lo_i;
    assign any_hi = |hi_i;

    always_comb begin
        if (any_lo)      idx_o = {1'b0, lowest_set(lo_i)};
        else if (any_hi) idx_o = {1'b1, lowest_set(hi_i)};
        else             idx_o = '0;
    end

    assign spurious_o = !(any_lo || any_hi);
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
    import gpio_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PINS-1:0]   pin_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [BANK_W-1:0] wdata_i,
    output logic [BANK_W-1:0] rdata_o,
    output logic              irq_o,
    output logic [IDX_W-1:0]  pend_idx_o,
    output logic              spurious_o
);
    logic [PINS-1:0]                     pin_s;
    logic [NUM_BANKS-1:0][BANK_W-1:0]    stat_w, en_w;
    bank_cfg_t                           cfg_w [NUM_BANKS];
    logic [PINS-1:0]                     stat_flat, en_flat;
    reg_kind_e                           kind;
    logic                                bsel;

    assign kind = decode_kind(addr_i);
    assign bsel = addr_i[1];

    gpio_irq_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(pin_i), .q(pin_s)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        gpio_irq_bank #(.BANK_ID(b)) u_bank (
            .clk     (clk),
            .rst     (rst),
            .sync_i  (pin_s[b*BANK_W +: BANK_W]),
            .wr_en   (wr_en_i),
            .wr_kind (kind),
            .wr_bank (bsel),
            .wdata   (wdata_i),
            .stat_o  (stat_w[b]),
            .en_o    (en_w[b]),
            .cfg_o   (cfg_w[b])
        );
    end

    assign stat_flat = stat_w;
    assign en_flat   = en_w;
    assign irq_o     = |(stat_flat & en_flat);

    gpio_irq_prio u_prio (
        .lo_i       (stat_w[0] & en_w[0]),
        .hi_i       (stat_w[1] & en_w[1]),
        .idx_o      (pend_idx_o),
        .spurious_o (spurious_o)
    );

    always_comb begin
        case (kind)
            RK_STAT: rdata_o = stat_w[bsel];
            RK_EN:   rdata_o = en_w[bsel];
            RK_TYPE: rdata_o = cfg_w[bsel].typ;
            RK_POL:  rdata_o = cfg_w[bsel].pol;
            RK_HOLD: rdata_o = cfg_w[bsel].hold;
            RK_FALL: rdata_o = cfg_w[bsel].fall;
            RK_RISE: rdata_o = cfg_w[bsel].rise;
            default: rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/gpio_irq_unit_chk.sv
module gpio_irq_unit_chk
    import gpio_irq_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             irq,
    input logic             spur,
    input logic [IDX_W-1:0] idx,
    input logic [PINS-1:0]  stat,
    input logic [PINS-1:0]  en
);
    // Request line and spurious flag come from separate logic; they must disagree.
    p_irq_vs_spur_r7: assert property (@(posedge clk) disable iff (rst)
        irq != spur);

    // Reported pin is really pending and enabled.
    p_idx_pending_r8: assert property (@(posedge clk) disable iff (rst)
        !spur |-> (stat[idx] && en[idx]));

    // A high-bank index implies nothing enabled is pending in the low bank.
    p_low_first_r8: assert property (@(posedge clk) disable iff (rst)
        (!spur && idx[IDX_W-1]) |-> ((stat[BANK_W-1:0] & en[BANK_W-1:0]) == '0));

    // Spurious reports pin 0.
    p_spur_idx_r8: assert property (@(posedge clk) disable iff (rst)
        spur |-> (idx == '0));

    // Leaving reset, nothing is enabled.
    p_reset_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!irq && en == '0));
endmodule

bind gpio_irq_unit gpio_irq_unit_chk u_chk (
    .clk  (clk),
    .rst  (rst),
    .irq  (irq_o),
    .spur (spurious_o),
    .idx  (pend_idx_o),
    .stat (stat_flat),
    .en   (en_flat)
);

// File: tb/gpio_irq_unit_test.sv
module gpio_irq_unit_test;
    localparam logic [5:0] A_ST_L = 6'h08, A_ST_H = 6'h0A;
    localparam logic [5:0] A_EN_L = 6'h0C, A_EN_H = 6'h0E;
    localparam logic [5:0] A_TY_L = 6'h10, A_TY_H = 6'h12;
    localparam logic [5:0] A_PO_L = 6'h14, A_PO_H = 6'h16;
    localparam logic [5:0] A_HO_L = 6'h18, A_HO_H = 6'h1A;
    localparam logic [5:0] A_FA_L = 6'h20, A_FA_H = 6'h22;
    localparam logic [5:0] A_RI_L = 6'h24, A_RI_H = 6'h26;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] pin = '0;
    logic [5:0]  addr = '0;
    logic        wr = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        irq, spur;
    logic [4:0]  idx;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    gpio_irq_unit uut (
        .clk(clk), .rst(rst), .pin_i(pin), .addr_i(addr), .wr_en_i(wr),
        .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .pend_idx_o(idx),
        .spurious_o(spur)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr_reg(input logic [5:0] a, input logic [15:0] d);
        addr = a; wdata = d; wr = 1'b1;
        @(posedge clk);
        #1;
        wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [5:0] a, output logic [15:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_stat(input string req, input logic [31:0] exp);
        logic [15:0] lo, hi;
        rd_reg(A_ST_L, lo);
        rd_reg(A_ST_H, hi);
        chk(req, {hi, lo}, exp);
    endtask

    task automatic clear_all();
        wr_reg(A_ST_L, 16'hFFFF);
        wr_reg(A_ST_H, 16'hFFFF);
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        tests++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [15:0] v;
        tick(3);
        rst = 1'b0;
        tick(1);

        // R2: reset state
        for (int k = 0; k < 12; k++) begin
            logic [5:0] a;
            a = (k < 2) ? (6'h0C + 6'(k * 2)) :
                (k < 10) ? (6'h10 + 6'((k - 2) * 2)) : (6'h20 + 6'((k - 10) * 2));
            if (k >= 6 && k < 10) a = 6'h20 + 6'((k - 6) * 2);
            rd_reg(a, v);
            chk("R2 reg reset", {16'h0, v}, 32'h0);
        end
        chk("R2 irq reset", {31'h0, irq}, 32'h0);
        chk("R2 spurious reset", {31'h0, spur}, 32'h1);

        // R1: readback of configuration and enable registers
        begin
            logic [5:0] al [12];
            al = '{A_EN_L, A_EN_H, A_TY_L, A_TY_H, A_PO_L, A_PO_H,
                   A_HO_L, A_HO_H, A_FA_L, A_FA_H, A_RI_L, A_RI_H};
            for (int k = 0; k < 12; k++) wr_reg(al[k], 16'h1357 * 16'(k + 1));
            for (int k = 0; k < 12; k++) begin
                rd_reg(al[k], v);
                chk("R1 readback", {16'h0, v}, {16'h0, 16'h1357 * 16'(k + 1)});
            end
            for (int k = 0; k < 12; k++) wr_reg(al[k], 16'h0000);
        end

        // R3: level, active high, one-hot sweep over all pins
        wr_reg(A_PO_L, 16'hFFFF);
        wr_reg(A_PO_H, 16'hFFFF);
        for (int i = 0; i < 32; i++) begin
            pin = 32'h1 << i;
            tick(3);
            chk($sformatf("R3 level high pin %0d", i), 0, 0);
            chk_stat("R3 level high", 32'h1 << i);
        end
        // R3: latency is exactly three edges
        pin = 32'h0;
        tick(3);
        pin = 32'h0000_0100;
        tick(2);
        chk_stat("R3 latency before", 32'h0);
        tick(1);
        chk_stat("R3 latency at", 32'h0000_0100);
        // R3: active low on low bank
        wr_reg(A_PO_L, 16'h0000);
        pin = 32'h0000_0008;
        tick(3);
        chk_stat("R3 level low", 32'h0000_FFF7);
        // R3/R6: clear-by-one in level mode does not stick
        wr_reg(A_ST_L, 16'hFFFF);
        chk_stat("R3 level refollows", 32'h0000_FFF7);

        // R4/R5: latched rising-edge sweep, with R7/R8 index checks
        pin = 32'h0;
        wr_reg(A_PO_L, 16'hFFFF);
        wr_reg(A_TY_L, 16'hFFFF); wr_reg(A_TY_H, 16'hFFFF);
        wr_reg(A_HO_L, 16'hFFFF); wr_reg(A_HO_H, 16'hFFFF);
        wr_reg(A_RI_L, 16'hFFFF); wr_reg(A_RI_H, 16'hFFFF);
        wr_reg(A_EN_L, 16'hFFFF); wr_reg(A_EN_H, 16'hFFFF);
        tick(3);
        clear_all();
        chk("R7 idle irq", {31'h0, irq}, 32'h0);
        for (int i = 0; i < 32; i++) begin
            pin = 32'h1 << i;
            tick(3);
            chk_stat("R4 rising", 32'h1 << i);
            chk("R7 irq set", {31'h0, irq}, 32'h1);
            chk("R8 index", {27'h0, idx}, i);
            chk("R8 not spurious", {31'h0, spur}, 32'h0);
            pin = 32'h0;
            tick(3);
            chk_stat("R5 latched after fall", 32'h1 << i);
            if (i < 16) wr_reg(A_ST_L, 16'h0000); else wr_reg(A_ST_H, 16'h0000);
            chk_stat("R6 zero write keeps", 32'h1 << i);
            if (i < 16) wr_reg(A_ST_L, 16'(32'h1 << i)); else wr_reg(A_ST_H, 16'(32'h1 << (i - 16)));
            chk_stat("R6 one write clears", 32'h0);
            chk("R8 spurious", {31'h0, spur}, 32'h1);
        end

        // R4: falling only
        wr_reg(A_RI_L, 16'h0000);
        wr_reg(A_FA_L, 16'hFFFF);
        pin = 32'h4;
        tick(3);
        chk_stat("R4 falling ignores rise", 32'h0);
        pin = 32'h0;
        tick(3);
        chk_stat("R4 falling", 32'h4);
        clear_all();
        // R4: both edges
        wr_reg(A_RI_L, 16'hFFFF);
        pin = 32'h4;
        tick(3);
        chk_stat("R4 both rise", 32'h4);
        clear_all();
        pin = 32'h0;
        tick(3);
        chk_stat("R4 both fall", 32'h4);
        clear_all();
        // R4: neither edge
        wr_reg(A_RI_L, 16'h0000);
        wr_reg(A_FA_L, 16'h0000);
        pin = 32'h4;
        tick(3);
        pin = 32'h0;
        tick(3);
        chk_stat("R4 no select", 32'h0);

        // R5: pass-through pulse lasts one cycle
        wr_reg(A_RI_L, 16'hFFFF);
        wr_reg(A_HO_L, 16'h0000);
        pin = 32'h20;
        tick(3);
        chk_stat("R5 pulse", 32'h20);
        tick(1);
        chk_stat("R5 pulse end", 32'h0);
        pin = 32'h0;
        wr_reg(A_HO_L, 16'hFFFF);
        tick(3);
        clear_all();

        // R8/R9: priority order and masking
        pin = (32'h1 << 20) | (32'h1 << 9) | (32'h1 << 5);
        tick(3);
        chk("R8 lowest low", {27'h0, idx}, 5);
        wr_reg(A_EN_L, 16'hFFDF);
        chk("R9 masked skipped", {27'h0, idx}, 9);
        chk_stat("R9 status kept", (32'h1 << 20) | (32'h1 << 9) | (32'h1 << 5));
        wr_reg(A_EN_L, 16'h0000);
        chk("R8 high after low", {27'h0, idx}, 20);
        wr_reg(A_EN_H, 16'h0000);
        chk("R9 irq masked", {31'h0, irq}, 32'h0);
        chk_stat("R9 status still", (32'h1 << 20) | (32'h1 << 9) | (32'h1 << 5));
        wr_reg(A_EN_L, 16'hFFFF);
        wr_reg(A_EN_H, 16'hFFFF);
        wr_reg(A_ST_L, 16'h0020);
        chk("R8 next low", {27'h0, idx}, 9);
        wr_reg(A_ST_L, 16'h0200);
        chk("R8 high bank", {27'h0, idx}, 20);
        wr_reg(A_ST_H, 16'h0010);
        chk("R8 none", {31'h0, spur}, 32'h1);
        chk("R7 none", {31'h0, irq}, 32'h0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule